// File: doc/BRIEF.md
# Bitplane Word Staging and Reload

This block sits between the video memory fetch and the pixel output of a planar display shifter. Bitplane words arrive one at a time on a strobe and are parked in a bank of staging registers. The bank fills strictly in arrival order. When the strobe delivers the word that completes a set, all planes move together into per-plane output shift registers. The shift registers then emit one pixel per clock, most significant bit first. The bits at the same position in each plane form the pixel's colour index. While no loaded pixels remain, the output shows border.

The occupancy of the staging bank is not cleared at line or frame boundaries. A line that fetches more words than a whole number of sets leaves the bank partly full. The next line then completes its first set sooner, and its picture starts further left. A second rule lets the bank lose a word. If display enable rises while the fetch side has been quiet for a full word slot, the most recently staged word is discarded and the occupancy drops by one. Low resolution uses all planes. Medium resolution uses half of them, and the upper index bits read zero.

Top module: `plane_stager`

## Requirements
- R1: After a synchronous reset, `fill_cnt` is 0, `border` is 1 and `pix_idx` is 0.
- R2: In low resolution (`res_sel` 00, and also 10 or 11), words are staged in arrival order. A strobe that arrives while `fill_cnt` is 3 causes a transfer: plane p receives the p-th staged word, plane 3 receives the arriving word, and `fill_cnt` becomes 0. From the next cycle, `pix_idx[p]` shows bit 15 of plane p, then bit 14, one bit per clock.
- R3: Each transfer yields exactly 16 pixel clocks with `border` at 0. After that, `border` is 1 and `pix_idx` is 0 until the next transfer.
- R4: `fill_cnt` holds its value across any cycle with no strobe and no discard, including while `disp_en` is low. So with one extra word per 40-clock line (five strobes, 4 clocks apart, the first strobe at the rise of `disp_en`), the first pixel appears 12, 8, 4, 0 and then 12 clocks after the line start on successive lines.
- R5: A discard happens when `disp_en` rises while `word_stb` is low, no strobe occurred in the previous 4 clocks, and `fill_cnt` is non-zero. `fill_cnt` then drops by one, and the next strobe refills that slot. A rise with a strobe fewer than 4 clocks earlier leaves `fill_cnt` unchanged.
- R6: A strobe that arrives while `disp_en` is low still stages its word and increments `fill_cnt`.
- R7: In medium resolution (`res_sel` 01), a strobe that arrives while `fill_cnt` is 1 or more causes a transfer. Plane 0 receives staged word 0 and plane 1 receives the arriving word. `pix_idx[3:2]` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| res_sel | input | 2 | Resolution select: 01 medium, any other value low |
| disp_en | input | 1 | Display enable |
| word_stb | input | 1 | Bitplane word strobe from memory |
| word_in | input | WORD_W | Bitplane word, valid with `word_stb` |
| pix_idx | output | NUM_PLANES | Pixel colour index, plane 0 in bit 0 |
| border | output | 1 | High while no loaded pixels remain |
| fill_cnt | output | $clog2(NUM_PLANES) | Number of staged words |

## Verification
The bound checker tracks a few properties on every clock: how a strobe moves the occupancy by one step or to zero, the one-step drop when a discard fires, that occupancy holds when neither event happens, that the border output is blank, and that the upper index bits stay zero in medium resolution. Several behaviours cannot be seen in a single cycle, and only the bench scenarios show them. These are the plane order and bit order of the emitted pixels, the exact 16-clock run length, the 12-8-4-0 drift of line start under a persistent leftover word, and which word a discard removes. The random phase compares every output against a reference model in the bench while resolution and enable change freely.

// File: rtl/plane_stager_pkg.sv
package plane_stager_pkg;

   typedef enum logic [1:0] {
      RES_LOW  = 2'b00,
      RES_MED  = 2'b01,
      RES_HIGH = 2'b10,
      RES_RSVD = 2'b11
   } res_e;

   // Number of planes in use for a resolution code, given the full plane count.
   function automatic int unsigned planes_used(input logic [1:0] res, input int unsigned full);
      return (res == RES_MED) ? full / 2 : full;
   endfunction

endpackage

// File: rtl/strobe_quiet_timer.sv
module strobe_quiet_timer #(
   parameter int unsigned SLOT_CYC = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic stb,
   output logic quiet
);
   localparam int unsigned QW = $clog2(SLOT_CYC + 1);
   localparam logic [QW-1:0] QMAX = QW'(SLOT_CYC);

   logic [QW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (rst)                gap_q <= QMAX;
      else if (stb)           gap_q <= '0;
      else if (gap_q != QMAX) gap_q <= gap_q + 1'b1;
   end

   assign quiet = (gap_q == QMAX);
endmodule

// File: rtl/stage_bank.sv
module stage_bank #(
   parameter int unsigned WORD_W        = 16,
   parameter int unsigned NUM_PLANES    = 4,
   parameter bit          CLEAR_ON_DROP = 1'b1
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic                                  stb,
   input  logic [WORD_W-1:0]                     word_in,
   input  logic                                  drop_req,
   input  logic [$clog2(NUM_PLANES)-1:0]         last_idx,
   output logic                                  xfer,
   output logic [NUM_PLANES-1:0][WORD_W-1:0]     stage_q,
   output logic [$clog2(NUM_PLANES)-1:0]         cnt_q
);
   localparam int unsigned CW = $clog2(NUM_PLANES);

   logic drop_ok;

   assign xfer    = stb && (cnt_q >= last_idx);
   assign drop_ok = drop_req && !stb && (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         stage_q <= '0;
      end else if (xfer) begin
         cnt_q <= '0;
      end else if (stb) begin
         stage_q[cnt_q] <= word_in;
         cnt_q          <= cnt_q + CW'(1);
      end else if (drop_ok) begin
         cnt_q <= cnt_q - CW'(1);
         if (CLEAR_ON_DROP) stage_q[cnt_q - CW'(1)] <= '0;
      end
   end
endmodule

// File: rtl/plane_shift.sv
module plane_shift #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned NUM_PLANES = 4
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              load,
   input  logic [NUM_PLANES-1:0][WORD_W-1:0] load_data,
   output logic [NUM_PLANES-1:0]             pix,
   output logic                              blank
);
   localparam int unsigned RW = $clog2(WORD_W + 1);

   logic [RW-1:0] run_q;
   logic          live;

   always_ff @(posedge clk) begin
      if (rst)               run_q <= '0;
      else if (load)         run_q <= RW'(WORD_W);
      else if (run_q != '0)  run_q <= run_q - 1'b1;
   end

   assign live  = (run_q != '0);
   assign blank = !live;

   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
      logic [WORD_W-1:0] sr_q;
      always_ff @(posedge clk) begin
         if (rst)       sr_q <= '0;
         else if (load) sr_q <= load_data[p];
         else if (live) sr_q <= {sr_q[WORD_W-2:0], 1'b0};
      end
      assign pix[p] = live & sr_q[WORD_W-1];
   end
endmodule

// File: rtl/plane_stager.sv
module plane_stager #(
   parameter int unsigned WORD_W        = 16,
   parameter int unsigned NUM_PLANES    = 4,
   parameter int unsigned SLOT_CYC      = 4,
   parameter bit          CLEAR_ON_DROP = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [1:0]                    res_sel,
   input  logic                          disp_en,
   input  logic                          word_stb,
   input  logic [WORD_W-1:0]             word_in,
   output logic [NUM_PLANES-1:0]         pix_idx,
   output logic                          border,
   output logic [$clog2(NUM_PLANES)-1:0] fill_cnt
);
   import plane_stager_pkg::*;

   localparam int unsigned CW = $clog2(NUM_PLANES);

   if (NUM_PLANES < 2 || (NUM_PLANES % 2) != 0) begin : g_bad_planes
      $error("plane_stager: NUM_PLANES must be even and at least 2");
   end
   if (WORD_W < 2) begin : g_bad_width
      $error("plane_stager: WORD_W must be at least 2");
   end
   if (SLOT_CYC < 1) begin : g_bad_slot
      $error("plane_stager: SLOT_CYC must be at least 1");
   end

   logic [CW-1:0]                     last_idx;
   logic                              de_q;
   logic                              quiet;
   logic                              drop_req;
   logic                              xfer;
   logic [NUM_PLANES-1:0][WORD_W-1:0] stage_q;
   logic [NUM_PLANES-1:0][WORD_W-1:0] xfer_data;

   assign last_idx = CW'(planes_used(res_sel, NUM_PLANES) - 1);

   always_ff @(posedge clk) begin
      if (rst) de_q <= 1'b0;
      else     de_q <= disp_en;
   end

   assign drop_req = disp_en && !de_q && quiet;

   strobe_quiet_timer #(.SLOT_CYC(SLOT_CYC)) u_quiet (
      .clk   (clk),
      .rst   (rst),
      .stb   (word_stb),
      .quiet (quiet)
   );

   stage_bank #(
      .WORD_W        (WORD_W),
      .NUM_PLANES    (NUM_PLANES),
      .CLEAR_ON_DROP (CLEAR_ON_DROP)
   ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .stb      (word_stb),
      .word_in  (word_in),
      .drop_req (drop_req),
      .last_idx (last_idx),
      .xfer     (xfer),
      .stage_q  (stage_q),
      .cnt_q    (fill_cnt)
   );

   // Planes below the last used one take staged words; the last takes the arriving word.
   for (genvar p = 0; p < NUM_PLANES; p++) begin : g_steer
      assign xfer_data[p] = (CW'(p) < last_idx)  ? stage_q[p] :
                            (CW'(p) == last_idx) ? word_in    : '0;
   end

   plane_shift #(.WORD_W(WORD_W), .NUM_PLANES(NUM_PLANES)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .load      (xfer),
      .load_data (xfer_data),
      .pix       (pix_idx),
      .blank     (border)
   );
endmodule

// File: rtl/plane_stager_chk.sv
module plane_stager_chk #(
   parameter int unsigned WORD_W     = 16,
   parameter int unsigned NUM_PLANES = 4,
   parameter int unsigned SLOT_CYC   = 4
) (
   input logic                          clk,
   input logic                          rst,
   input logic [1:0]                    res_sel,
   input logic                          disp_en,
   input logic                          word_stb,
   input logic [NUM_PLANES-1:0]         pix_idx,
   input logic                          border,
   input logic [$clog2(NUM_PLANES)-1:0] fill_cnt
);
   localparam int unsigned CW = $clog2(NUM_PLANES);
   localparam int unsigned GW = $clog2(SLOT_CYC + 1);

   logic [CW-1:0] lim;
   logic          de_prev;
   logic [GW-1:0] gap;
   logic          de_rise;
   logic          slot_quiet;

   assign lim = (res_sel == 2'b01) ? CW'(NUM_PLANES / 2 - 1) : CW'(NUM_PLANES - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         de_prev <= 1'b0;
         gap     <= GW'(SLOT_CYC);
      end else begin
         de_prev <= disp_en;
         if (word_stb)                gap <= '0;
         else if (gap != GW'(SLOT_CYC)) gap <= gap + 1'b1;
      end
   end

   assign de_rise    = disp_en && !de_prev;
   assign slot_quiet = (gap == GW'(SLOT_CYC));

   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (fill_cnt == '0 && border && pix_idx == '0));

   a_r2_transfer_empties: assert property (@(posedge clk) disable iff (rst)
      (word_stb && fill_cnt >= lim) |=> (fill_cnt == '0 && !border));

   a_r6_stage_step: assert property (@(posedge clk) disable iff (rst)
      (word_stb && fill_cnt < lim) |=> (fill_cnt == $past(fill_cnt) + CW'(1)));

   a_r5_drop_step: assert property (@(posedge clk) disable iff (rst)
      (de_rise && !word_stb && slot_quiet && fill_cnt != '0) |=> (fill_cnt == $past(fill_cnt) - CW'(1)));

   a_r4_fill_holds: assert property (@(posedge clk) disable iff (rst)
      (!word_stb && !(de_rise && slot_quiet)) |=> $stable(fill_cnt));

   a_r3_border_blank: assert property (@(posedge clk) disable iff (rst)
      border |-> (pix_idx == '0));

   a_r7_med_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (word_stb && fill_cnt >= lim && res_sel == 2'b01) |=> (pix_idx[NUM_PLANES-1:NUM_PLANES/2] == '0));
endmodule

bind plane_stager plane_stager_chk #(
   .WORD_W     (WORD_W),
   .NUM_PLANES (NUM_PLANES),
   .SLOT_CYC   (SLOT_CYC)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .res_sel  (res_sel),
   .disp_en  (disp_en),
   .word_stb (word_stb),
   .pix_idx  (pix_idx),
   .border   (border),
   .fill_cnt (fill_cnt)
);

// File: tb/plane_stager_bench.sv
module plane_stager_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  res_sel;
   logic        disp_en;
   logic        word_stb;
   logic [15:0] word_in;
   logic [3:0]  pix_idx;
   logic        border;
   logic [1:0]  fill_cnt;

   int n_chk  = 0;
   int n_fail = 0;

   // reference model state
   int          m_cnt;
   logic [15:0] m_st [4];
   logic [15:0] m_sh [4];
   int          m_run;
   int          m_gap;
   bit          m_dep;

   always #2 clk = ~clk;

   plane_stager u_plane_stager (
      .clk(clk), .rst(rst), .res_sel(res_sel), .disp_en(disp_en),
      .word_stb(word_stb), .word_in(word_in),
      .pix_idx(pix_idx), .border(border), .fill_cnt(fill_cnt)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_run = 0; m_gap = 4; m_dep = 0;
      for (int p = 0; p < 4; p++) begin m_st[p] = '0; m_sh[p] = '0; end
   endtask

   task automatic model_step(input bit stb, input logic [15:0] w, input bit de, input logic [1:0] res);
      int  lim;
      bit  load;
      lim  = (res == 2'b01) ? 1 : 3;
      load = stb && (m_cnt >= lim);
      if (load) begin
         for (int p = 0; p < 4; p++)
            m_sh[p] = (p < lim) ? m_st[p] : (p == lim) ? w : 16'h0;
         m_run = 16;
         m_cnt = 0;
      end else begin
         if (stb) begin
            m_st[m_cnt] = w; m_cnt++;
         end else if (de && !m_dep && m_gap == 4 && m_cnt > 0) begin
            m_cnt--; m_st[m_cnt] = '0;
         end
         if (m_run > 0) begin
            for (int p = 0; p < 4; p++) m_sh[p] = m_sh[p] << 1;
            m_run--;
         end
      end
      if (stb) m_gap = 0; else if (m_gap < 4) m_gap++;
      m_dep = de;
   endtask

   function automatic logic [3:0] model_pix();
      if (m_run == 0) return 4'h0;
      return {m_sh[3][15], m_sh[2][15], m_sh[1][15], m_sh[0][15]};
   endfunction

   task automatic cyc(input bit stb, input logic [15:0] w, input bit de, input bit cmp);
      word_stb = stb; word_in = w; disp_en = de;
      if (rst) model_reset(); else model_step(stb, w, de, res_sel);
      @(negedge clk);
      if (cmp && !rst) begin
         chk(pix_idx == model_pix(), "R2", "pix_idx vs model", pix_idx, model_pix());
         chk(border == (m_run == 0), "R3", "border vs model", border, (m_run == 0));
         chk(fill_cnt == m_cnt[1:0], "R4", "fill_cnt vs model", fill_cnt, m_cnt);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cyc(0, 16'h0, 0, 0);
      cyc(0, 16'h0, 0, 0);
      rst = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] wa, wc, wd, we, wx, wy;
      int          first_low;
      int          exp_off [5];
      void'($urandom(32'd5511));
      res_sel = 2'b00; word_stb = 0; word_in = '0; disp_en = 0; rst = 1;
      @(negedge clk);
      do_reset();

      // R1: reset state
      chk(fill_cnt == 0, "R1", "fill_cnt after reset", fill_cnt, 0);
      chk(border == 1,   "R1", "border after reset", border, 1);
      chk(pix_idx == 0,  "R1", "pix_idx after reset", pix_idx, 0);

      // R4: one extra word per line, first pixel offsets drift 12,8,4,0,12
      exp_off = '{12, 8, 4, 0, 12};
      for (int ln = 0; ln < 5; ln++) begin
         first_low = -1;
         for (int i = 0; i < 40; i++) begin
            cyc((i % 4 == 0) && (i <= 16), 16'h1000 + 16'(ln * 40 + i), i < 20, 1);
            if (first_low < 0 && !border) first_low = i;
         end
         chk(first_low == exp_off[ln], "R4", "line start offset", first_low, exp_off[ln]);
      end

      // R6 and R5: strobes with enable low stage, then quiet rise discards the last one
      do_reset();
      wa = 16'hA5C3; wc = 16'h0F0F; wd = 16'h3333; we = 16'hFFFF;
      cyc(1, wa, 0, 1);
      cyc(1, 16'hDEAD, 0, 1);
      chk(fill_cnt == 2, "R6", "fill after strobes with enable low", fill_cnt, 2);
      for (int i = 0; i < 6; i++) cyc(0, 16'h0, 0, 1);
      cyc(0, 16'h0, 1, 1);
      chk(fill_cnt == 1, "R5", "fill after quiet enable rise", fill_cnt, 1);
      cyc(1, wc, 1, 1);
      cyc(1, wd, 1, 1);
      cyc(1, we, 1, 1);
      for (int k = 0; k < 4; k++) begin
         logic [3:0] e;
         e = {we[15-k], wd[15-k], wc[15-k], wa[15-k]};
         chk(pix_idx == e, "R5", "pixel after discard refill", pix_idx, e);
         if (k < 3) cyc(0, 16'h0, 1, 1);
      end

      // R5: rise with a recent strobe keeps the word
      do_reset();
      cyc(1, 16'h1234, 0, 1);
      cyc(0, 16'h0, 0, 1);
      cyc(0, 16'h0, 1, 1);
      chk(fill_cnt == 1, "R5", "fill after non-quiet rise", fill_cnt, 1);

      // R2 and R3: low-resolution pixel order and run length
      do_reset();
      cyc(1, 16'h8001, 1, 1);
      cyc(1, 16'h4002, 1, 1);
      cyc(1, 16'h2004, 1, 1);
      cyc(1, 16'hF008, 1, 1);
      chk(pix_idx == 4'b1001, "R2", "first pixel low res", pix_idx, 4'b1001);
      chk(fill_cnt == 0, "R2", "fill after transfer", fill_cnt, 0);
      for (int i = 0; i < 15; i++) cyc(0, 16'h0, 1, 1);
      chk(border == 0 && pix_idx == 4'b0001, "R2", "last pixel low res", {border, pix_idx}, 5'b00001);
      cyc(0, 16'h0, 1, 1);
      chk(border == 1 && pix_idx == 0, "R3", "border after 16 pixels", {border, pix_idx}, 5'b10000);

      // R7: medium resolution uses two planes
      do_reset();
      res_sel = 2'b01;
      wx = 16'hC000; wy = 16'h6000;
      cyc(1, wx, 1, 1);
      cyc(1, wy, 1, 1);
      chk(pix_idx == 4'b0001 && fill_cnt == 0, "R7", "medium first pixel", {fill_cnt, pix_idx}, 6'b000001);
      cyc(0, 16'h0, 1, 1);
      chk(pix_idx == 4'b0011, "R7", "medium second pixel", pix_idx, 4'b0011);
      cyc(0, 16'h0, 1, 1);
      chk(pix_idx == 4'b0010, "R7", "medium third pixel", pix_idx, 4'b0010);
      res_sel = 2'b00;

      // random phase against the model
      do_reset();
      begin
         bit de_r;
         de_r = 0;
         for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 5) de_r = !de_r;
            if ($urandom_range(99) < 1) res_sel = 2'($urandom_range(3));
            cyc($urandom_range(99) < 30, 16'($urandom), de_r, 1);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule